// File: doc/BRIEF.md
# EISA Command Strobe Generator

This block is the central-resource logic that times the command strobe of a bus cycle started by a 32-bit or 16-bit master. When the master's start pulse is sampled, the block checks that the slave has returned a size response matching the master's width. If it matches, the block raises the command strobe on that same clock edge, which is the edge at which the master drops its start pulse.

The strobe is then held for as long as the slave signals not-ready. It is released at the first clock edge that samples the slave ready. The exception is a burst: when the slave reported itself burstable at the start and the master keeps its burst request up, the strobe stays asserted across successive transfers. It ends at the first ready edge after the master drops the request.

A counter watches how long the slave holds ready negated and raises a sticky timeout flag. Three status outputs, in the style of the narrower bus, are decoded combinationally from the byte enables and the direction while a cycle is in progress. Every pin is modelled active-high. A cycle whose size response does not match leaves the strobe idle, so that a conversion path outside this block can take over.

Top module: `eisa_cmd_strobe`

## Requirements
- R1: An active-low asynchronous reset drives `cmd_o` and `ready_timeout_o` to 0 at once, even in the middle of a cycle or after a timeout.
- R2: A 32-bit master (`narrow_mst_i`=0) that presents `start_i`=1 while `size32_ack_i`=1 gets `cmd_o`=1 from the clock edge that samples `start_i`.
- R3: A 16-bit master (`narrow_mst_i`=1) needs `size16_ack_i`=1 for the strobe. When the size response does not match the master's width, or when neither response is present, `cmd_o` stays 0.
- R4: Outside a burst, `cmd_o` stays 1 on every edge that samples `slv_ready_i`=0. It falls at the first edge that samples `slv_ready_i`=1.
- R5: If `slv_burst_i`=1 when the start pulse is sampled, `cmd_o` stays 1 across any ready edge at which `mst_burst_i`=1. It falls at the first ready edge at which `mst_burst_i`=0.
- R6: `mst_burst_i` has no effect in a cycle whose slave did not report itself burstable: `cmd_o` falls at the first ready edge.
- R7: `ready_timeout_o` rises after WAIT_LIMIT consecutive edges that sample `slv_ready_i`=0 while `cmd_o`=1. It stays set until the next edge that samples `start_i`=1, which clears it.
- R8: A cycle is in progress when `start_i`=1 or `cmd_o`=1. During a cycle, `hi_byte_o` = `be_i[1]`|`be_i[3]`, `wr_stat_o` = `wr_i` and `rd_stat_o` = !`wr_i`. Outside a cycle, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse from the master |
| narrow_mst_i | input | 1 | Master is 16 bits wide (valid with start) |
| size32_ack_i | input | 1 | Slave reports 32-bit size |
| size16_ack_i | input | 1 | Slave reports 16-bit size |
| slv_ready_i | input | 1 | Slave ready (0 extends the cycle) |
| slv_burst_i | input | 1 | Slave is burstable (valid with start) |
| mst_burst_i | input | 1 | Master burst request |
| be_i | input | 4 | Byte enables |
| wr_i | input | 1 | 1 = write, 0 = read |
| cmd_o | output | 1 | Command strobe |
| hi_byte_o | output | 1 | High byte lane in use |
| rd_stat_o | output | 1 | Read status |
| wr_stat_o | output | 1 | Write status |
| ready_timeout_o | output | 1 | Slave held not-ready too long (sticky) |

## Verification
The bench builds the block with WAIT_LIMIT set to 4 in place of the default 21. This brings the timeout edge, its sticky hold and its clearing by a new start within a few cycles. It also leaves room to show that three not-ready edges do not set the flag. All other behaviour is independent of the parameter, so it is exercised exactly as it runs with the default.

// File: rtl/cmdstb_pkg.sv
package cmdstb_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_CMD  = 1'b1
  } phase_e;

  typedef struct packed {
    logic hi_byte;
    logic rd;
    logic wr;
  } isa_stat_t;
endpackage

// File: rtl/cmdstb_size_match.sv
module cmdstb_size_match (
  input  logic narrow_i,
  input  logic ack32_i,
  input  logic ack16_i,
  output logic match_o
);
  // The slave's reply must agree with the master's width.
  always_comb begin
    if (narrow_i) match_o = ack16_i;
    else          match_o = ack32_i;
  end
endmodule

// File: rtl/cmdstb_fsm.sv
module cmdstb_fsm
  import cmdstb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic match_i,
  input  logic slv_burst_i,
  input  logic ready_i,
  input  logic mst_burst_i,
  output logic cmd_o
);
  phase_e ph_q, ph_d;
  logic   burst_ok_q, burst_ok_d;
  logic   burst_en;

  always_comb begin
    ph_d       = ph_q;
    burst_ok_d = burst_ok_q;
    burst_en   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i && match_i) begin
          ph_d       = PH_CMD;
          burst_ok_d = slv_burst_i;
          burst_en   = 1'b1;
        end
      end
      PH_CMD: begin
        // A ready edge ends the strobe unless both sides keep bursting.
        if (ready_i && !(burst_ok_q && mst_burst_i)) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      burst_ok_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (burst_en) burst_ok_q <= burst_ok_d;
    end
  end

  assign cmd_o = (ph_q == PH_CMD);
endmodule

// File: rtl/cmdstb_wait_timer.sv
module cmdstb_wait_timer #(
  parameter int unsigned WAIT_LIMIT = 21
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic waiting_i,
  input  logic clear_i,
  output logic timeout_o
);
  localparam int unsigned CW = $clog2(WAIT_LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          flag_q, flag_d;
  logic          hit;

  assign hit    = waiting_i && (cnt_q == CW'(WAIT_LIMIT - 1));
  assign cnt_en = waiting_i || (cnt_q != '0);

  always_comb begin
    if (!waiting_i)                      cnt_d = '0;
    else if (cnt_q == CW'(WAIT_LIMIT))   cnt_d = cnt_q;
    else                                 cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (clear_i)  flag_d = 1'b0;
    else if (hit) flag_d = 1'b1;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign timeout_o = flag_q;
endmodule

// File: rtl/cmdstb_status.sv
module cmdstb_status
  import cmdstb_pkg::*;
(
  input  logic      start_i,
  input  logic      cmd_i,
  input  logic [3:0] be_i,
  input  logic      wr_i,
  output isa_stat_t stat_o
);
  logic active;
  assign active = start_i | cmd_i;

  always_comb begin
    stat_o = '0;
    if (active) begin
      stat_o.hi_byte = be_i[1] | be_i[3];
      stat_o.wr      = wr_i;
      stat_o.rd      = ~wr_i;
    end
  end
endmodule

// File: rtl/eisa_cmd_strobe.sv
module eisa_cmd_strobe
  import cmdstb_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 21
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       narrow_mst_i,
  input  logic       size32_ack_i,
  input  logic       size16_ack_i,
  input  logic       slv_ready_i,
  input  logic       slv_burst_i,
  input  logic       mst_burst_i,
  input  logic [3:0] be_i,
  input  logic       wr_i,
  output logic       cmd_o,
  output logic       hi_byte_o,
  output logic       rd_stat_o,
  output logic       wr_stat_o,
  output logic       ready_timeout_o
);
  logic      match;
  logic      cmd;
  isa_stat_t stat;

  cmdstb_size_match u_match (
    .narrow_i (narrow_mst_i),
    .ack32_i  (size32_ack_i),
    .ack16_i  (size16_ack_i),
    .match_o  (match)
  );

  cmdstb_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .match_i     (match),
    .slv_burst_i (slv_burst_i),
    .ready_i     (slv_ready_i),
    .mst_burst_i (mst_burst_i),
    .cmd_o       (cmd)
  );

  cmdstb_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .waiting_i (cmd & ~slv_ready_i),
    .clear_i   (start_i),
    .timeout_o (ready_timeout_o)
  );

  cmdstb_status u_stat (
    .start_i (start_i),
    .cmd_i   (cmd),
    .be_i    (be_i),
    .wr_i    (wr_i),
    .stat_o  (stat)
  );

  assign cmd_o     = cmd;
  assign hi_byte_o = stat.hi_byte;
  assign rd_stat_o = stat.rd;
  assign wr_stat_o = stat.wr;
endmodule

// File: rtl/eisa_cmd_strobe_chk.sv
module eisa_cmd_strobe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic narrow_mst_i,
  input logic size32_ack_i,
  input logic size16_ack_i,
  input logic slv_ready_i,
  input logic mst_burst_i,
  input logic cmd_o,
  input logic hi_byte_o,
  input logic rd_stat_o,
  input logic wr_stat_o,
  input logic ready_timeout_o
);
  assert_cmd_needs_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_o) |-> $past(start_i));

  assert_cmd_size_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_o) |-> $past(narrow_mst_i ? size16_ack_i : size32_ack_i));

  assert_cmd_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o && !slv_ready_i) |=> cmd_o);

  assert_cmd_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o && slv_ready_i && !mst_burst_i) |=> !cmd_o);

  assert_timeout_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_timeout_o) |-> ($past(cmd_o) && !$past(slv_ready_i)));

  assert_timeout_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_timeout_o);

  assert_stat_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !cmd_o) |-> (!hi_byte_o && !rd_stat_o && !wr_stat_o));

  assert_stat_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stat_o && wr_stat_o));
endmodule

bind eisa_cmd_strobe eisa_cmd_strobe_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .narrow_mst_i    (narrow_mst_i),
  .size32_ack_i    (size32_ack_i),
  .size16_ack_i    (size16_ack_i),
  .slv_ready_i     (slv_ready_i),
  .mst_burst_i     (mst_burst_i),
  .cmd_o           (cmd_o),
  .hi_byte_o       (hi_byte_o),
  .rd_stat_o       (rd_stat_o),
  .wr_stat_o       (wr_stat_o),
  .ready_timeout_o (ready_timeout_o)
);

// File: tb/test_eisa_cmd_strobe.sv
module test_eisa_cmd_strobe;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, narrow, a32, a16, rdy, sburst, mburst, wr;
  logic [3:0] be;
  logic       cmd, hb, rd_s, wr_s, tmo;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  cmd;
    logic  tmo;
    logic  hb;
    logic  rd;
    logic  wr;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  eisa_cmd_strobe #(.WAIT_LIMIT(4)) i_eisa_cmd_strobe (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .start_i         (start),
    .narrow_mst_i    (narrow),
    .size32_ack_i    (a32),
    .size16_ack_i    (a16),
    .slv_ready_i     (rdy),
    .slv_burst_i     (sburst),
    .mst_burst_i     (mburst),
    .be_i            (be),
    .wr_i            (wr),
    .cmd_o           (cmd),
    .hi_byte_o       (hb),
    .rd_stat_o       (rd_s),
    .wr_stat_o       (wr_s),
    .ready_timeout_o (tmo)
  );

  // Driver: apply one clock's inputs and queue the outputs expected after the edge.
  task automatic drv(input logic st, input logic nm, input logic x32, input logic x16,
                     input logic ry, input logic sb, input logic mb,
                     input logic [3:0] b, input logic w,
                     input logic ecmd, input logic eto, input string req);
    exp_t e;
    logic cyc;
    @(negedge clk);
    start = st; narrow = nm; a32 = x32; a16 = x16;
    rdy = ry; sburst = sb; mburst = mb; be = b; wr = w;
    cyc   = st | ecmd;          // R8: cycle in progress
    e.cmd = ecmd;
    e.tmo = eto;
    e.hb  = cyc & (b[1] | b[3]);
    e.wr  = cyc & w;
    e.rd  = cyc & ~w;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({cmd, tmo, hb, rd_s, wr_s} !== {e.cmd, e.tmo, e.hb, e.rd, e.wr}) begin
        fails++;
        $display("FAIL %s: cmd/tmo/hb/rd/wr actual=%b%b%b%b%b expected=%b%b%b%b%b",
                 e.req, cmd, tmo, hb, rd_s, wr_s, e.cmd, e.tmo, e.hb, e.rd, e.wr);
      end
    end
  end

  task automatic direct_check(input logic ok, input string req, input logic [4:0] act);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: cmd/tmo/hb/rd/wr actual=%b expected=00000", req, act);
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 0; narrow = 0; a32 = 0; a16 = 0; rdy = 1; sburst = 0; mburst = 0;
    be = 4'b0000; wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    direct_check({cmd, tmo, hb, rd_s, wr_s} == 5'b0, "R1 reset state", {cmd, tmo, hb, rd_s, wr_s});

    // R2: 32-bit master, immediate ready; R8 write status
    drv(1,0,1,0,1,0,0,4'b0001,1, 1,0,"R2 strobe on start edge");
    drv(0,0,0,0,1,0,0,4'b0001,1, 0,0,"R4 single transfer ends");

    // R4: wait states, R8 read status with high lane
    drv(1,0,1,0,1,0,0,4'b0010,0, 1,0,"R4 start");
    drv(0,0,0,0,0,0,0,4'b0010,0, 1,0,"R8 hold with read status");
    drv(0,0,0,0,0,0,0,4'b0010,0, 1,0,"R4 hold not ready");
    drv(0,0,0,0,1,0,0,4'b0010,0, 0,0,"R4 release on ready");
    drv(0,0,0,0,1,0,0,4'b1010,1, 0,0,"R8 idle status zero");

    // R3: size matching
    drv(1,1,0,1,1,0,0,4'b1100,0, 1,0,"R3 16-bit match");
    drv(0,0,0,0,1,0,0,4'b1100,0, 0,0,"R3 16-bit end");
    drv(1,0,0,1,1,0,0,4'b1100,0, 0,0,"R3 32-bit master with 16 ack");
    drv(0,0,0,0,1,0,0,4'b1100,0, 0,0,"R3 stays idle");
    drv(1,1,1,0,1,0,0,4'b1100,0, 0,0,"R3 16-bit master with 32 ack");
    drv(1,0,0,0,1,0,0,4'b1100,0, 0,0,"R3 no size ack");
    drv(0,0,0,0,1,0,0,4'b0000,0, 0,0,"R3 idle after");

    // R5: burst
    drv(1,0,1,0,1,1,1,4'b1111,0, 1,0,"R5 burst start");
    drv(0,0,0,0,1,0,1,4'b1111,0, 1,0,"R5 burst transfer 1");
    drv(0,0,0,0,1,0,1,4'b1111,0, 1,0,"R5 burst transfer 2");
    drv(0,0,0,0,0,0,1,4'b1111,0, 1,0,"R5 burst wait");
    drv(0,0,0,0,0,0,0,4'b1111,0, 1,0,"R5 burst drop while waiting");
    drv(0,0,0,0,1,0,0,4'b1111,0, 0,0,"R5 burst end");

    // R6: burst request with non-burstable slave
    drv(1,0,1,0,1,0,0,4'b1111,1, 1,0,"R6 start");
    drv(0,0,0,0,1,1,1,4'b1111,1, 0,0,"R6 burst request ignored");

    // R7: timeout
    drv(1,0,1,0,1,0,0,4'b0001,0, 1,0,"R7 start");
    drv(0,0,0,0,0,0,0,4'b0001,0, 1,0,"R7 wait 1");
    drv(0,0,0,0,0,0,0,4'b0001,0, 1,0,"R7 wait 2");
    drv(0,0,0,0,0,0,0,4'b0001,0, 1,0,"R7 wait 3 no flag");
    drv(0,0,0,0,0,0,0,4'b0001,0, 1,1,"R7 flag at limit");
    drv(0,0,0,0,1,0,0,4'b0001,0, 0,1,"R7 flag sticky on end");
    drv(0,0,0,0,1,0,0,4'b0001,0, 0,1,"R7 flag sticky idle");
    drv(1,0,1,0,1,0,0,4'b0001,0, 1,0,"R7 flag cleared by start");
    drv(0,0,0,0,1,0,0,4'b0001,0, 0,0,"R7 end clean");

    // R1: reset mid-cycle with flag set
    drv(1,0,1,0,1,0,0,4'b0000,0, 1,0,"R1 pre start");
    drv(0,0,0,0,0,0,0,4'b0000,0, 1,0,"R1 pre wait 1");
    drv(0,0,0,0,0,0,0,4'b0000,0, 1,0,"R1 pre wait 2");
    drv(0,0,0,0,0,0,0,4'b0000,0, 1,0,"R1 pre wait 3");
    drv(0,0,0,0,0,0,0,4'b0000,0, 1,1,"R1 pre flag");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    direct_check(cmd == 1'b0 && tmo == 1'b0, "R1 async reset mid-cycle", {cmd, tmo, hb, rd_s, wr_s});
    @(negedge clk);
    rst_n = 1'b1;
    drv(0,0,0,0,1,0,0,4'b0000,0, 0,0,"R1 idle after reset");
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule